// File: doc/BRIEF.md
# USB IN Endpoint Memory-Read Engine

This block copies a contiguous byte region of memory into the buffer of a USB device IN endpoint, one packet at a time. Software supplies an inclusive first and last byte address, picks a maximum packet size, chooses whether a short final packet is closed with an explicit end-of-packet marker, and pulses `start`. The engine fetches one byte at a time over a simple request/acknowledge read port. It hands each byte to the endpoint FIFO and flags the last byte of every packet.

When the last byte has been accepted by the endpoint, the engine drops `busy` and sets a sticky interrupt. This only means the data is in the endpoint buffer. The host may not have read it yet, so a separate `drained` status combines "transfer finished" with the endpoint's empty indication to confirm delivery. A start request is refused, and an error flag set, when the endpoint is not in direct-access mode, when the last address is below the first, or when the packet-size code is not defined.

Top module: `usb_in_dma`

## Requirements
- R1: An accepted transfer delivers exactly `cfg_end_addr - cfg_start_addr + 1` bytes to the endpoint. They go in ascending address order, starting at `cfg_start_addr`, and each byte is the memory data read at that address.
- R2: `cfg_pkt_sel` codes 0, 1, 2, 3 and 4 select packets of 8, 16, 32, 64 and 512 bytes. `ep_last` is high on the last byte of every full packet and on the final byte of the transfer, and low on all other bytes, so the final packet is short when the size is not a whole number of packets.
- R3: A 1035-byte region with 512-byte packets is delivered as three packets of 512, 512 and 11 bytes.
- R4: A `start` pulse while idle with a legal setup sets `busy`. `busy` clears by itself after the last byte. A `start` pulse while `busy` is ignored and does not change the transfer in progress.
- R5: `irq_end` becomes 1 on the clock edge after the endpoint accepts the final byte, on the same edge where `busy` falls. It then stays 1 until `irq_clr` is pulsed.
- R6: `drained` is 1 only when the most recent accepted transfer has finished and `ep_empty` is 1. It is 0 while a transfer runs.
- R7: A `start` with `cfg_direct` = 0, with `cfg_end_addr` below `cfg_start_addr`, or with `cfg_pkt_sel` above 4 is rejected. It sets `err`, leaves `busy` at 0 and makes no memory or endpoint access. `err` clears when a later start is accepted.
- R8: When `cfg_eop_en` was 1 at the start, `ep_eop` is high together with the final byte if that byte closes a short packet. It is low on every other byte, and on every byte when `cfg_eop_en` was 0 or the size is a whole number of packets.
- R9: While `ep_ready` is 0, `ep_wr` stays high with stable `ep_data`. While `mem_ack` is 0, `mem_rd_req` stays high with stable `mem_addr`. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_addr | input | AW | First byte address, inclusive |
| cfg_end_addr | input | AW | Last byte address, inclusive |
| cfg_pkt_sel | input | 3 | Packet size code: 0=8, 1=16, 2=32, 3=64, 4=512 bytes |
| cfg_eop_en | input | 1 | Mark a short final packet with `ep_eop` |
| cfg_direct | input | 1 | Endpoint is in direct-access mode |
| start | input | 1 | One-cycle request to begin a transfer |
| irq_clr | input | 1 | Clears `irq_end` |
| busy | output | 1 | Transfer in progress (self-clearing enable) |
| irq_end | output | 1 | Sticky end-address interrupt |
| err | output | 1 | Sticky rejected-start flag |
| drained | output | 1 | Transfer finished and endpoint empty |
| mem_rd_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory byte address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` valid |
| mem_rdata | input | 8 | Read data byte |
| ep_wr | output | 1 | Byte offered to the endpoint FIFO |
| ep_data | output | 8 | Byte value |
| ep_last | output | 1 | Byte closes a packet |
| ep_eop | output | 1 | Explicit end-of-packet marker for a short final packet |
| ep_ready | input | 1 | Endpoint FIFO can take a byte |
| ep_empty | input | 1 | Endpoint buffer has drained to the host |

## Verification
Byte order, data, `ep_last` and `ep_eop` have no fixed latency. They are checked at each endpoint handshake: the bench samples `ep_wr` and `ep_ready` just after the falling edge, when the acceptance at the next rising edge is already decided. It then compares the byte with its index in the expected stream. `irq_end` and the fall of `busy` are due exactly one edge after the final handshake, so they are checked at the next falling edge. Reject outcomes and `drained` are read a few cycles after the stimulus, when any register would already have changed. Random `mem_ack` and `ep_ready` gaps stretch every transfer so that each stall path is exercised.

// File: rtl/usb_in_dma.sv
module usb_in_dma #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [AW-1:0] cfg_end_addr,
  input  logic [2:0]    cfg_pkt_sel,
  input  logic          cfg_eop_en,
  input  logic          cfg_direct,
  input  logic          start,
  input  logic          irq_clr,
  output logic          busy,
  output logic          irq_end,
  output logic          err,
  output logic          drained,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          ep_wr,
  output logic [7:0]    ep_data,
  output logic          ep_last,
  output logic          ep_eop,
  input  logic          ep_ready,
  input  logic          ep_empty
);
  localparam int PW = 10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_PUSH} state_t;

  state_t          state;
  logic [AW-1:0]   addr, end_q;
  logic [PW-1:0]   psz_m1, pcnt;
  logic [7:0]      data_q;
  logic            eop_q, irq_q, err_q, done_q;

  function automatic logic [PW-1:0] size_m1(input logic [2:0] sel);
    case (sel)
      3'd0:    return PW'(7);
      3'd1:    return PW'(15);
      3'd2:    return PW'(31);
      3'd3:    return PW'(63);
      default: return PW'(511);
    endcase
  endfunction

  logic req_ok, req_bad, last_byte, pkt_end, push_done;

  assign busy      = state != S_IDLE;
  assign req_ok    = start && !busy && cfg_direct && (cfg_end_addr >= cfg_start_addr) && (cfg_pkt_sel <= 3'd4);
  assign req_bad   = start && !busy && !req_ok;
  assign last_byte = addr == end_q;
  assign pkt_end   = (pcnt == psz_m1) || last_byte;
  assign push_done = ep_wr && ep_ready;

  assign mem_rd_req = state == S_FETCH;
  assign mem_addr   = addr;
  assign ep_wr      = state == S_PUSH;
  assign ep_data    = data_q;
  assign ep_last    = ep_wr && pkt_end;
  assign ep_eop     = ep_wr && last_byte && eop_q && (pcnt != psz_m1);
  assign irq_end    = irq_q;
  assign err        = err_q;
  assign drained    = done_q && ep_empty && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr   <= '0;
      end_q  <= '0;
      psz_m1 <= '0;
      pcnt   <= '0;
      data_q <= '0;
      eop_q  <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (push_done && last_byte) irq_q <= 1'b1;
      else if (irq_clr)           irq_q <= 1'b0;

      if (req_bad)     err_q <= 1'b1;
      else if (req_ok) err_q <= 1'b0;

      case (state)
        S_IDLE: if (req_ok) begin
          addr   <= cfg_start_addr;
          end_q  <= cfg_end_addr;
          psz_m1 <= size_m1(cfg_pkt_sel);
          eop_q  <= cfg_eop_en;
          pcnt   <= '0;
          done_q <= 1'b0;
          state  <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_PUSH;
        end
        S_PUSH: if (ep_ready) begin
          if (last_byte) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            addr  <= addr + AW'(1);
            pcnt  <= pkt_end ? '0 : pcnt + PW'(1);
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_in_dma_chk.sv
module usb_in_dma_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_clr,
  input logic          busy,
  input logic          irq_end,
  input logic          drained,
  input logic          mem_rd_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          ep_wr,
  input logic [7:0]    ep_data,
  input logic          ep_last,
  input logic          ep_eop,
  input logic          ep_ready,
  input logic          ep_empty
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ep_wr && !ep_ready |=> ep_wr && $stable(ep_data));              // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_ack |=> mem_rd_req && $stable(mem_addr));    // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end && !irq_clr |=> irq_end);                               // R5
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_end);                                       // R5
  AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ep_eop |-> ep_last && ep_wr);                                   // R8
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !busy && ep_empty);                                 // R6
endmodule

bind usb_in_dma usb_in_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr), .busy(busy),
  .irq_end(irq_end), .drained(drained), .mem_rd_req(mem_rd_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .ep_wr(ep_wr),
  .ep_data(ep_data), .ep_last(ep_last), .ep_eop(ep_eop),
  .ep_ready(ep_ready), .ep_empty(ep_empty)
);

// File: tb/tb_usb_in_dma.sv
`timescale 1ns/1ps
module tb_usb_in_dma;
  localparam int AW = 16;

  logic          clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_start_addr = '0, cfg_end_addr = '0;
  logic [2:0]    cfg_pkt_sel = '0;
  logic          cfg_eop_en = 0, cfg_direct = 1, start = 0, irq_clr = 0;
  logic          busy, irq_end, err, drained, mem_rd_req, ep_wr, ep_last, ep_eop;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 0, ep_ready = 0, ep_empty = 0;
  logic [7:0]    mem_rdata, ep_data;

  usb_in_dma #(.AW(AW)) dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_byte(mem_addr);

  int total = 0, bad = 0;
  int exp_start, exp_size, exp_p, idx, pkt_len, npkts, last_len;
  bit exp_eop, irq_pend, xfer_done, mon_on;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    ep_ready = ($urandom % 4) != 0;
    mem_ack  = ($urandom % 3) != 0;
    #1;
    if (irq_pend) begin
      irq_pend = 0;
      chk(irq_end === 1'b1, "R5 irq one edge after last byte", irq_end, 1);
      chk(busy === 1'b0, "R4 busy self-clears", busy, 0);
      xfer_done = 1;
    end
    if (rst_n && ep_wr && ep_ready) begin
      if (!mon_on || idx >= exp_size) begin
        chk(0, "R1 unexpected endpoint byte", idx, exp_size);
      end else begin
        chk(ep_data === mem_byte(AW'(exp_start + idx)), "R1 byte value", ep_data, mem_byte(AW'(exp_start + idx)));
        chk(ep_last === ((idx % exp_p == exp_p - 1) || idx == exp_size - 1), "R2 packet boundary",
            ep_last, (idx % exp_p == exp_p - 1) || idx == exp_size - 1);
        chk(ep_eop === (exp_eop && idx == exp_size - 1 && (exp_size % exp_p) != 0), "R8 eop marker",
            ep_eop, exp_eop && idx == exp_size - 1 && (exp_size % exp_p) != 0);
        pkt_len++;
        if (ep_last) begin npkts++; last_len = pkt_len; pkt_len = 0; end
        idx++;
        if (idx == exp_size) irq_pend = 1;
      end
    end
  end

  function automatic int psize(input int sel);
    return sel == 4 ? 512 : (8 << sel);
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_xfer(input int s, input int n, input int sel, input bit eop, input bit poke);
    @(negedge clk);
    cfg_start_addr = AW'(s); cfg_end_addr = AW'(s + n - 1);
    cfg_pkt_sel = 3'(sel); cfg_eop_en = eop; cfg_direct = 1;
    exp_start = s; exp_size = n; exp_p = psize(sel); exp_eop = eop;
    idx = 0; pkt_len = 0; npkts = 0; last_len = 0; xfer_done = 0; mon_on = 1;
    pulse_start();
    #2;
    chk(busy === 1'b1, "R4 busy after start", busy, 1);
    chk(drained === 1'b0, "R6 drained low while running", drained, 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      cfg_start_addr = AW'(s + 100); cfg_end_addr = AW'(s + 101);
      cfg_pkt_sel = 3'd0; cfg_eop_en = !eop;
      pulse_start();
    end
    for (int k = 0; k < 20000 && !xfer_done; k++) @(negedge clk);
    #2;
    chk(xfer_done, "R5 transfer completion", xfer_done, 1);
    chk(idx == n, "R1 byte count", idx, n);
    chk(npkts == (n + exp_p - 1) / exp_p, "R2 packet count", npkts, (n + exp_p - 1) / exp_p);
    chk(err === 1'b0, "R7 err clear after accepted start", err, 0);
    chk(drained === 1'b0, "R6 drained needs ep_empty", drained, 0);
    ep_empty = 1; #1;
    chk(drained === 1'b1, "R6 drained after finish", drained, 1);
    ep_empty = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(irq_end === 1'b1, "R5 irq sticky", irq_end, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0; #2;
    chk(irq_end === 1'b0, "R5 irq cleared", irq_end, 0);
    mon_on = 0;
  endtask

  task automatic run_bad(input int s, input int e, input int sel, input bit direct, input string why);
    @(negedge clk);
    cfg_start_addr = AW'(s); cfg_end_addr = AW'(e); cfg_pkt_sel = 3'(sel); cfg_direct = direct;
    exp_size = 0; idx = 0; mon_on = 1;
    pulse_start();
    repeat (4) @(negedge clk);
    #2;
    chk(err === 1'b1, {"R7 err set: ", why}, err, 1);
    chk(busy === 1'b0, {"R7 no busy: ", why}, busy, 0);
    chk(idx == 0, {"R7 no endpoint write: ", why}, idx, 0);
    chk(irq_end === 1'b0, {"R7 no irq: ", why}, irq_end, 0);
    cfg_direct = 1; mon_on = 0;
  endtask

  initial begin
    #1_900_000;
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #2;
    chk(busy === 0 && irq_end === 0 && err === 0, "R4 reset idle", {busy, irq_end, err}, 0);
    chk(ep_wr === 0 && mem_rd_req === 0 && drained === 0, "R6 reset outputs", {ep_wr, mem_rd_req, drained}, 0);
    rst_n = 1;

    for (int sel = 0; sel < 4; sel++) begin
      int p = psize(sel);
      int sizes[7] = '{1, 2, p - 1, p, p + 1, 2 * p, 2 * p + 5};
      foreach (sizes[i]) run_xfer(16'h0100 + 37 * i + sel, sizes[i], sel, (i % 2) == 0, 0);
    end

    run_xfer(16'h1000, 1035, 4, 1, 0);
    chk(npkts == 3, "R3 three packets", npkts, 3);
    chk(last_len == 11, "R3 final packet 11 bytes", last_len, 11);

    run_xfer(16'h2000, 40, 1, 0, 1);

    run_bad(16'h0300, 16'h0310, 1, 0, "shared mode");
    run_xfer(16'h0400, 9, 0, 1, 0);
    run_bad(16'h0500, 16'h04FF, 2, 1, "end below start");
    run_bad(16'h0600, 16'h0610, 5, 1, "bad size code");
    run_xfer(16'hFFF0, 16, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule